// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Acknowledge Unit

This block pairs two eight-line priority controllers, a primary and a secondary, to serve sixteen interrupt request lines. Lines 0 to 7 belong to the primary and lines 8 to 15 to the secondary. Whenever the secondary holds a deliverable request, it is passed into primary line 2 as an edge event. The request pin for primary line 2 is not used. The processor interrupt line follows the primary's deliverable state.

When the processor pulses the acknowledge strobe, the block picks a winner. It marks that line in service, unless auto end-of-interrupt is selected. It retires the edge request and returns an 8-bit vector and a 4-bit global line number in the next cycle. Both values stay on the outputs until the next acknowledge. If the winner is line 2, the secondary is acknowledged as well. When there is no winner, the acknowledge is spurious and falls back to line 7 of the controller concerned.

Vector bases, per-line masks, per-line trigger modes and the auto end-of-interrupt mode are static configuration inputs. Priority is fixed: the lowest index wins.

Top module: `pic_cascade`

## Requirements
- R1: After reset, irq_o, vec_o and line_o are all 0 and no request is pending.
- R2: The primary resolves a fixed priority in which the lowest index wins. For a primary winner other than line 2, vec_o = {mbase_i[7:3], idx} and line_o = idx. The low three bits of a base input are ignored.
- R3: A deliverable secondary request sets primary line 2 as an edge event and raises irq_o two cycles after the request rises. req_i[2] has no effect.
- R4: An acknowledge whose primary winner is line 2 also acknowledges the secondary winner. It yields vec_o = {sbase_i[7:3], idx} and line_o = 8 + idx.
- R5: If primary line 2 wins but the secondary has nothing deliverable, the acknowledge yields {sbase_i[7:3], 3'd7} and line_o = 15.
- R6: An acknowledge with irq_o low yields {mbase_i[7:3], 3'd7} and line_o = 7, and sets no in-service bit.
- R7: A set bit of mask_i (bit n for line n) keeps that line from being delivered, including bit 2, which masks the cascade.
- R8: With auto_eoi_i = 0, an in-service line blocks delivery of every line of equal or lower priority on its controller. A line of higher priority is still delivered.
- R9: With auto_eoi_i = 1, an acknowledge leaves nothing in service.
- R10: An edge line (trig_i bit 0) is cleared by its acknowledge. A level line (trig_i bit 1) stays pending while its request is high.
- R11: Level mode is possible only for primary lines 3 to 7 and secondary lines 9, 10, 11, 12, 14 and 15. Lines 0, 1, 2, 8 and 13 are always edge lines, whatever trig_i says.
- R12: In the acknowledge cycle of primary line 2, the cascade is not forwarded again. In the following cycle it is re-evaluated from the updated secondary state.
- R13: vec_o and line_o update one cycle after ack_i and hold between acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request lines; bits 15:8 go to the secondary |
| trig_i | input | 16 | Trigger mode per line: 1 = level, 0 = edge |
| mask_i | input | 16 | Mask per line: 1 = blocked |
| auto_eoi_i | input | 1 | Auto end-of-interrupt on acknowledge |
| mbase_i | input | 8 | Primary vector base; bits 7:3 used |
| sbase_i | input | 8 | Secondary vector base; bits 7:3 used |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| irq_o | output | 1 | Interrupt line to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |
| line_o | output | 4 | Global line number of the last acknowledge |

## Verification
The acknowledge path is driven with single primary lines, with several primary lines together, with secondary lines alone, and with secondary and primary lines mixed. These patterns separate fixed priority from cascade routing. Masks on ordinary lines and on the cascade line show that a masked winner gives way to the next line in priority. An idle acknowledge, a lone request on primary line 2 and a secondary level request withdrawn before the acknowledge separate the two spurious fallbacks. Edge and level requests held high across an acknowledge, including trigger bits that the fixed masks discard, separate request retirement from re-forwarding through the cascade.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int unsigned UNIT_LINES = 8;
  localparam int unsigned IDX_W      = $clog2(UNIT_LINES);
  localparam int unsigned ALL_LINES  = 2 * UNIT_LINES;
  localparam int unsigned GLINE_W    = IDX_W + 1;
  typedef logic [UNIT_LINES-1:0] lines_t;
  typedef logic [IDX_W-1:0]      idx_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_cascade_pkg::*;
#(
  parameter lines_t TRIG_MASK  = 8'hF8,
  parameter lines_t PULSE_MASK = 8'h00
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  lines_t req_i,
  input  lines_t trig_i,
  input  lines_t mask_i,
  input  logic   auto_eoi_i,
  input  logic   ack_i,
  output logic   del_o,
  output idx_t   win_o
);
  lines_t irr_q, isr_q, last_q, irr_n, isr_n, clr, lvl;
  logic   p_any, s_any;
  idx_t   p_idx, s_idx;

  pic_prio #(.N(UNIT_LINES)) i_pend (.bits_i(irr_q & ~mask_i), .any_o(p_any), .idx_o(p_idx));
  pic_prio #(.N(UNIT_LINES)) i_serv (.bits_i(isr_q),           .any_o(s_any), .idx_o(s_idx));

  assign del_o = p_any && (!s_any || (p_idx < s_idx));
  assign win_o = p_idx;

  always_comb begin
    clr   = (ack_i && del_o) ? (lines_t'(1) << p_idx) : '0;
    lvl   = trig_i & TRIG_MASK & ~PULSE_MASK;
    // level lines track the pin; edge lines latch until acknowledged
    irr_n = (lvl & req_i)
          | (~lvl & ((irr_q & ~clr) | (req_i & ~last_q) | (req_i & PULSE_MASK)));
    isr_n = isr_q | (auto_eoi_i ? '0 : clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= req_i;
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_cascade_pkg::*;
#(
  parameter int unsigned CASCADE_LINE     = 2,
  parameter int unsigned SPUR_LINE        = 7,
  parameter lines_t      PRI_TRIG_MASK    = 8'hF8,
  parameter lines_t      SEC_TRIG_MASK    = 8'hDE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ALL_LINES-1:0] req_i,
  input  logic [ALL_LINES-1:0] trig_i,
  input  logic [ALL_LINES-1:0] mask_i,
  input  logic                 auto_eoi_i,
  input  logic [7:0]           mbase_i,
  input  logic [7:0]           sbase_i,
  input  logic                 ack_i,
  output logic                 irq_o,
  output logic [7:0]           vec_o,
  output logic [GLINE_W-1:0]   line_o
);
  localparam idx_t   CAS_IDX  = idx_t'(CASCADE_LINE);
  localparam idx_t   SPUR_IDX = idx_t'(SPUR_LINE);
  localparam lines_t CAS_BIT  = lines_t'(1) << CASCADE_LINE;

  logic   m_del, s_del, m_cas_win, ack_s, fwd;
  idx_t   m_win, s_win;
  lines_t m_req;
  logic [7:0]         vec_n;
  logic [GLINE_W-1:0] line_n;

  assign m_cas_win = m_del && (m_win == CAS_IDX);
  assign ack_s     = ack_i && m_cas_win;
  // hold off forwarding while the cascade itself is being acknowledged
  assign fwd       = s_del && !ack_s;

  always_comb begin
    m_req = req_i[UNIT_LINES-1:0];
    m_req[CASCADE_LINE] = fwd;
  end

  pic_unit #(.TRIG_MASK(PRI_TRIG_MASK), .PULSE_MASK(CAS_BIT)) i_pri (
    .clk_i, .rst_ni,
    .req_i(m_req), .trig_i(trig_i[UNIT_LINES-1:0]), .mask_i(mask_i[UNIT_LINES-1:0]),
    .auto_eoi_i, .ack_i, .del_o(m_del), .win_o(m_win)
  );

  pic_unit #(.TRIG_MASK(SEC_TRIG_MASK), .PULSE_MASK('0)) i_sec (
    .clk_i, .rst_ni,
    .req_i(req_i[ALL_LINES-1:UNIT_LINES]), .trig_i(trig_i[ALL_LINES-1:UNIT_LINES]),
    .mask_i(mask_i[ALL_LINES-1:UNIT_LINES]),
    .auto_eoi_i, .ack_i(ack_s), .del_o(s_del), .win_o(s_win)
  );

  assign irq_o = m_del;

  always_comb begin
    if (!m_del) begin
      vec_n  = {mbase_i[7:IDX_W], SPUR_IDX};
      line_n = {1'b0, SPUR_IDX};
    end else if (!m_cas_win) begin
      vec_n  = {mbase_i[7:IDX_W], m_win};
      line_n = {1'b0, m_win};
    end else if (s_del) begin
      vec_n  = {sbase_i[7:IDX_W], s_win};
      line_n = {1'b1, s_win};
    end else begin
      vec_n  = {sbase_i[7:IDX_W], SPUR_IDX};
      line_n = {1'b1, SPUR_IDX};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o  <= '0;
      line_o <= '0;
    end else if (ack_i) begin
      vec_o  <= vec_n;
      line_o <= line_n;
    end
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       irq_o,
  input logic [7:0] mbase_i,
  input logic [7:0] sbase_i,
  input logic [7:0] vec_o,
  input logic [3:0] line_o
);
  a_r13_hold_between_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ($stable(vec_o) && $stable(line_o)));

  a_r2_vec_low_matches_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (vec_o[2:0] == line_o[2:0]));

  a_r4_base_by_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (line_o[3] ? (vec_o[7:3] == $past(sbase_i[7:3]))
                         : (vec_o[7:3] == $past(mbase_i[7:3]))));

  a_r6_idle_ack_line7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (line_o == 4'd7));
endmodule

bind pic_cascade pic_cascade_chk i_pic_cascade_chk (
  .clk_i, .rst_ni, .ack_i, .irq_o, .mbase_i, .sbase_i, .vec_o, .line_o
);

// File: tb/test_pic_cascade.sv
`timescale 1ns/1ps
module test_pic_cascade;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0, trig_i = '0, mask_i = '0;
  logic        auto_eoi_i = 1'b0, ack_i = 1'b0;
  logic [7:0]  mbase_i = 8'h0B, sbase_i = 8'h73;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic [3:0]  line_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pic_cascade i_pic_cascade (
    .clk_i, .rst_ni, .req_i, .trig_i, .mask_i, .auto_eoi_i,
    .mbase_i, .sbase_i, .ack_i, .irq_o, .vec_o, .line_o
  );

  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] req;
    logic        irq;
    logic [7:0]  vec;
    logic [3:0]  line;
  } row_t;

  // bases 0x0B and 0x73 resolve to 0x08 and 0x70
  localparam row_t ROWS [11] = '{
    '{16'h0000, 16'h0001, 1'b1, 8'h08, 4'd0},
    '{16'h0000, 16'h0030, 1'b1, 8'h0C, 4'd4},
    '{16'h0000, 16'h0200, 1'b1, 8'h71, 4'd9},
    '{16'h0000, 16'h0208, 1'b1, 8'h71, 4'd9},
    '{16'h0000, 16'h8002, 1'b1, 8'h09, 4'd1},
    '{16'h0001, 16'h0003, 1'b1, 8'h09, 4'd1},
    '{16'h0004, 16'h0110, 1'b1, 8'h0C, 4'd4},
    '{16'h0000, 16'h0000, 1'b0, 8'h0F, 4'd7},
    '{16'h0000, 16'h0004, 1'b0, 8'h0F, 4'd7},
    '{16'h0000, 16'hC000, 1'b1, 8'h76, 4'd14},
    '{16'h0100, 16'h0300, 1'b1, 8'h71, 4'd9}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    req_i = '0; ack_i = 1'b0;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    cyc(1);
    ack_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(1);
    rst_ni = 1'b1;
    // R1 reset state
    do_reset();
    chk("R1 irq", irq_o, 0);
    chk("R1 vec", vec_o, 0);
    chk("R1 line", line_o, 0);

    // R2 R3 R4 R6 R7 table
    foreach (ROWS[k]) begin
      do_reset();
      trig_i = '0; auto_eoi_i = 1'b0; mask_i = ROWS[k].mask;
      req_i = ROWS[k].req;
      cyc(3);
      chk($sformatf("R2/R3/R7 row %0d irq", k), irq_o, ROWS[k].irq);
      pulse_ack();
      chk($sformatf("R2/R4/R6 row %0d vec", k), vec_o, ROWS[k].vec);
      chk($sformatf("R2/R4/R6 row %0d line", k), line_o, ROWS[k].line);
    end
    mask_i = '0;

    // R8 nesting without auto end-of-interrupt
    do_reset();
    req_i = 16'h0008; cyc(3);
    pulse_ack();
    chk("R8 first vec", vec_o, 8'h0B);
    req_i = 16'h0028; cyc(3);
    chk("R8 lower blocked", irq_o, 0);
    req_i = 16'h002A; cyc(3);
    chk("R8 higher delivered", irq_o, 1);
    pulse_ack();
    chk("R8 higher line", line_o, 1);
    cyc(1);
    chk("R8 all blocked", irq_o, 0);

    // R9 auto end-of-interrupt
    do_reset();
    auto_eoi_i = 1'b1;
    req_i = 16'h0008; cyc(3);
    pulse_ack();
    req_i = 16'h0028; cyc(3);
    chk("R9 lower not blocked", irq_o, 1);
    pulse_ack();
    chk("R9 vec", vec_o, 8'h0D);

    // R10 edge retired, level stays
    do_reset();
    auto_eoi_i = 1'b1; trig_i = '0;
    req_i = 16'h0008; cyc(3);
    pulse_ack();
    chk("R10 edge cleared", irq_o, 0);
    do_reset();
    trig_i = 16'h0008;
    req_i = 16'h0008; cyc(3);
    pulse_ack();
    chk("R10 level vec", vec_o, 8'h0B);
    chk("R10 level stays", irq_o, 1);

    // R11 trigger mask forces edge
    do_reset();
    trig_i = 16'h0001;
    req_i = 16'h0001; cyc(3);
    pulse_ack();
    chk("R11 primary line0 edge", irq_o, 0);
    do_reset();
    trig_i = 16'h0100;
    req_i = 16'h0100; cyc(3);
    pulse_ack();
    chk("R11 secondary line8 vec", vec_o, 8'h70);
    cyc(3);
    chk("R11 secondary line8 edge", irq_o, 0);

    // R12 cascade re-forward after acknowledge, R13 hold
    do_reset();
    trig_i = 16'h0200;
    req_i = 16'h0200; cyc(3);
    pulse_ack();
    chk("R12 vec", vec_o, 8'h71);
    chk("R12 no forward in ack cycle", irq_o, 0);
    cyc(1);
    chk("R12 re-forwarded", irq_o, 1);
    req_i = 16'h0001; cyc(3);
    chk("R13 vec held", vec_o, 8'h71);
    chk("R13 line held", line_o, 9);

    // R5 secondary spurious
    do_reset();
    auto_eoi_i = 1'b0; trig_i = 16'h0200;
    req_i = 16'h0200; cyc(3);
    chk("R5 irq latched", irq_o, 1);
    req_i = '0; cyc(2);
    pulse_ack();
    chk("R5 vec", vec_o, 8'h77);
    chk("R5 line", line_o, 15);

    // R6 idle acknowledge sets nothing in service
    do_reset();
    trig_i = '0;
    pulse_ack();
    chk("R6 vec", vec_o, 8'h0F);
    req_i = 16'h0080; cyc(3);
    chk("R6 line7 deliverable", irq_o, 1);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule